// File: doc/BRIEF.md
# Active-Priority Register Access Gate

This block sits between a core's coprocessor-register access path and a bank of four 32-bit active-priority registers. For every valid request it first checks the encoding fields against the one encoding that addresses the bank, and takes the register index from the low two bits of the second opcode field. It then runs a fixed-order chain of checks. The chain depends on the privilege level of the request, on how many priority bits the build implements, and on a set of routing, trap and enable controls. The result is exactly one outcome: undefined, trap to level 2, trap to level 3, access to the virtual copy, or access to the physical copy.

The outcome and its syndrome code are combinational in the cycle of the request. A permitted write lands in the chosen bank (physical or virtual) on the next rising clock edge. Read data is registered: it shows the selected register one cycle after a permitted read and holds its value otherwise. Exception entry and priority-drop logic are handled elsewhere. The requester uses the outcome vector to decide what to do next.

Top module: `apr_access_gate`

## Requirements
- R1: A request addresses the bank only when coproc=4'b1111, opc1=3'b000, crn=4'b1100, crm=4'b1000 and opc2[2]=1; the register index is opc2[1:0]. Any other encoding, or an idle request, gives an all-zero outcome and writes nothing.
- R2: Index 1 is undefined when PRIO_BITS < 6, and indices 2 and 3 are undefined when PRIO_BITS < 7. This check comes before every other check. An unimplemented register is never written.
- R3: Every addressed request at privilege level 0 is undefined.
- R4: At level 1 the checks run in this order. (a) Undefined if level 3 is present, level-3 FIQ routing is set, the secure-debug priority-undefine input is set, and level 3 is not 32-bit or the core is not in monitor mode. (b) Trap to level 2 if level 2 is enabled and its c12 trap bit is set. (c) Undefined if the level-1 register-interface enable is 0. (d) Trap to level 2 if level 2 is enabled and its group-0 trap bit is set. (e) Virtual access if level 2 is enabled and FIQ virtualisation is set. (f) If the routing condition of (a) holds without the priority input: undefined when the secure-debug undefine input is set, otherwise trap to level 3. (g) Otherwise physical access.
- R5: At level 2 the checks run in this order. (a) Undefined if level 3 is present, FIQ routing is set and the priority-undefine input is set. (b) Undefined if the level-2 enable is 0. (c) If level 3 is present and FIQ routing is set: undefined when the secure-debug undefine input is set, otherwise trap to level 3. (d) Otherwise physical access. Monitor mode and all level-2 trap and virtualisation bits have no effect at this level.
- R6: At level 3 the access is undefined when the level-3 enable is 0, and is physical otherwise.
- R7: The outcome is one-hot, with bit 0 undefined, bit 1 trap to level 2, bit 2 trap to level 3, bit 3 virtual and bit 4 physical. The syndrome is 8'h03 with a level-2 trap and 8'h00 in every other case.
- R8: A write with the physical or virtual outcome stores wdata into the selected register of that bank at the next edge. Writes with any other outcome leave both banks unchanged.
- R9: A read with the physical or virtual outcome puts the selected register of that bank on rdata one cycle later. Otherwise rdata holds its value.
- R10: Synchronous reset clears all registers of both banks and rdata to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| enc_coproc | input | 4 | Coprocessor number field |
| enc_opc1 | input | 3 | First opcode field |
| enc_crn | input | 4 | Primary register field |
| enc_crm | input | 4 | Secondary register field |
| enc_opc2 | input | 3 | Second opcode field; bits [1:0] are the index |
| wdata | input | 32 | Write data |
| priv_lvl | input | 2 | Privilege level 0..3 |
| l2_enabled | input | 1 | Level 2 is enabled |
| l3_present | input | 1 | Level 3 is implemented |
| l3_is_32b | input | 1 | Level 3 runs the 32-bit state |
| in_monitor | input | 1 | Core is in monitor mode |
| sd_undef_prio | input | 1 | Secure-debug undefine, priority form |
| sd_undef | input | 1 | Secure-debug undefine, late form |
| l3_fiq_route | input | 1 | FIQ routed to level 3 |
| l2_trap_c12 | input | 1 | Level-2 trap on c12 accesses |
| ifen_l1 | input | 1 | Level-1 register-interface enable |
| ifen_l2 | input | 1 | Level-2 register-interface enable |
| ifen_l3 | input | 1 | Level-3 register-interface enable |
| l2_trap_grp0 | input | 1 | Level-2 trap of all group-0 accesses |
| l2_fiq_virt | input | 1 | FIQ virtualisation by level 2 |
| outcome | output | 5 | One-hot outcome vector |
| syndrome | output | 8 | Trap syndrome code |
| rdata | output | 32 | Registered read data |

## Verification
The chain is tried at all four privilege levels across every combination of the thirteen control inputs. Each result is compared with a model of the ordered chain, which separates a correct priority order from one where two checks are swapped or where a level-only exemption, such as the monitor-mode test, leaks to another level. A short table of hand-picked patterns pins each rung of the chain on its own. Directed sequences show that writes reach only the bank the outcome names, that blocked or mis-encoded writes leave stored values unchanged, and that a build with fewer priority bits rejects the upper indices even at level 3 with its enable set.

// File: rtl/apr_gate_pkg.sv
package apr_gate_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 2;
  localparam int NREG   = 1 << IDX_W;
  localparam int OC_W   = 5;
  localparam int SYN_W  = 8;
  localparam logic [SYN_W-1:0] L2_TRAP_CODE = 8'h03;

  typedef enum logic [2:0] {
    V_UNDEF = 3'd0,
    V_TRAP2 = 3'd1,
    V_TRAP3 = 3'd2,
    V_VIRT  = 3'd3,
    V_PHYS  = 3'd4
  } verdict_e;

  typedef struct packed {
    logic l2_en;
    logic l3_present;
    logic l3_32b;
    logic mon;
    logic sd_prio;
    logic sd_late;
    logic fiq_route;
    logic trap_c12;
    logic en_l1;
    logic en_l2;
    logic en_l3;
    logic trap_grp0;
    logic fiq_virt;
  } ctl_t;

  function automatic logic index_present(input int idx, input int prio_bits);
    if (idx == 0) return 1'b1;
    if (idx == 1) return prio_bits >= 6;
    return prio_bits >= 7;
  endfunction
endpackage

// File: rtl/apr_decode.sv
module apr_decode
  import apr_gate_pkg::*;
#(
  parameter int PRIO_BITS = 7
) (
  input  logic [3:0]       coproc,
  input  logic [2:0]       opc1,
  input  logic [3:0]       crn,
  input  logic [3:0]       crm,
  input  logic [2:0]       opc2,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output logic             idx_ok
);
  logic [NREG-1:0] present_mask;

  for (genvar g = 0; g < NREG; g++) begin : g_mask
    assign present_mask[g] = index_present(g, PRIO_BITS);
  end

  assign hit = (coproc == 4'b1111) && (opc1 == 3'b000) && (crn == 4'b1100)
            && (crm == 4'b1000) && opc2[2];
  assign idx    = opc2[IDX_W-1:0];
  assign idx_ok = present_mask[idx];
endmodule

// File: rtl/apr_policy.sv
module apr_policy
  import apr_gate_pkg::*;
(
  input  logic [1:0] lvl,
  input  ctl_t       c,
  input  logic       idx_ok,
  output verdict_e   verdict
);
  logic route_l1;
  logic route_l2;

  always_comb begin
    route_l2 = c.l3_present && c.fiq_route;
    route_l1 = route_l2 && (!c.l3_32b || !c.mon);
    verdict  = V_UNDEF;
    if (!idx_ok) begin
      verdict = V_UNDEF;
    end else begin
      case (lvl)
        2'd1: begin
          if (route_l1 && c.sd_prio)           verdict = V_UNDEF;
          else if (c.l2_en && c.trap_c12)      verdict = V_TRAP2;
          else if (!c.en_l1)                   verdict = V_UNDEF;
          else if (c.l2_en && c.trap_grp0)     verdict = V_TRAP2;
          else if (c.l2_en && c.fiq_virt)      verdict = V_VIRT;
          else if (route_l1)                   verdict = c.sd_late ? V_UNDEF : V_TRAP3;
          else                                 verdict = V_PHYS;
        end
        2'd2: begin
          if (route_l2 && c.sd_prio)           verdict = V_UNDEF;
          else if (!c.en_l2)                   verdict = V_UNDEF;
          else if (route_l2)                   verdict = c.sd_late ? V_UNDEF : V_TRAP3;
          else                                 verdict = V_PHYS;
        end
        2'd3:    verdict = c.en_l3 ? V_PHYS : V_UNDEF;
        default: verdict = V_UNDEF;
      endcase
    end
  end
endmodule

// File: rtl/apr_bank.sv
module apr_bank
  import apr_gate_pkg::*;
#(
  parameter int PRIO_BITS = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [NREG-1:0]              present;
  logic [NREG-1:0][DATA_W-1:0]  regs;

  for (genvar g = 0; g < NREG; g++) begin : g_present
    assign present[g] = index_present(g, PRIO_BITS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '0;
    end else if (we && present[idx]) begin
      regs[idx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= regs[idx];
  end

  // R8
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (we && present[idx]) |=> (regs[$past(idx)] == $past(wdata)));

  // R2
  absent_stays_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (we && !present[idx]) |=> (regs[$past(idx)] == '0));
endmodule

// File: rtl/apr_access_gate.sv
module apr_access_gate
  import apr_gate_pkg::*;
#(
  parameter int PRIO_BITS = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [3:0]        enc_coproc,
  input  logic [2:0]        enc_opc1,
  input  logic [3:0]        enc_crn,
  input  logic [3:0]        enc_crm,
  input  logic [2:0]        enc_opc2,
  input  logic [31:0]       wdata,
  input  logic [1:0]        priv_lvl,
  input  logic              l2_enabled,
  input  logic              l3_present,
  input  logic              l3_is_32b,
  input  logic              in_monitor,
  input  logic              sd_undef_prio,
  input  logic              sd_undef,
  input  logic              l3_fiq_route,
  input  logic              l2_trap_c12,
  input  logic              ifen_l1,
  input  logic              ifen_l2,
  input  logic              ifen_l3,
  input  logic              l2_trap_grp0,
  input  logic              l2_fiq_virt,
  output logic [4:0]        outcome,
  output logic [7:0]        syndrome,
  output logic [31:0]       rdata
);
  logic             hit;
  logic             idx_ok;
  logic [IDX_W-1:0] idx;
  ctl_t             ctl;
  verdict_e         verdict;
  logic             live;
  logic             p_we, p_re, v_we, v_re;
  logic             rd_virt_q;
  logic [DATA_W-1:0] p_rdata, v_rdata;

  assign ctl = '{l2_en: l2_enabled, l3_present: l3_present, l3_32b: l3_is_32b,
                 mon: in_monitor, sd_prio: sd_undef_prio, sd_late: sd_undef,
                 fiq_route: l3_fiq_route, trap_c12: l2_trap_c12,
                 en_l1: ifen_l1, en_l2: ifen_l2, en_l3: ifen_l3,
                 trap_grp0: l2_trap_grp0, fiq_virt: l2_fiq_virt};

  apr_decode #(.PRIO_BITS(PRIO_BITS)) u_dec (
    .coproc(enc_coproc), .opc1(enc_opc1), .crn(enc_crn), .crm(enc_crm),
    .opc2(enc_opc2), .hit(hit), .idx(idx), .idx_ok(idx_ok)
  );

  apr_policy u_pol (.lvl(priv_lvl), .c(ctl), .idx_ok(idx_ok), .verdict(verdict));

  assign live     = req_valid && hit;
  assign outcome  = live ? (OC_W'(1) << verdict) : '0;
  assign syndrome = (live && verdict == V_TRAP2) ? L2_TRAP_CODE : '0;

  assign p_we = live && (verdict == V_PHYS) &&  req_write;
  assign p_re = live && (verdict == V_PHYS) && !req_write;
  assign v_we = live && (verdict == V_VIRT) &&  req_write;
  assign v_re = live && (verdict == V_VIRT) && !req_write;

  apr_bank #(.PRIO_BITS(PRIO_BITS)) u_phys (
    .clk(clk), .rst(rst), .we(p_we), .re(p_re), .idx(idx),
    .wdata(wdata), .rdata(p_rdata)
  );

  apr_bank #(.PRIO_BITS(PRIO_BITS)) u_virt (
    .clk(clk), .rst(rst), .we(v_we), .re(v_re), .idx(idx),
    .wdata(wdata), .rdata(v_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst)       rd_virt_q <= 1'b0;
    else if (p_re) rd_virt_q <= 1'b0;
    else if (v_re) rd_virt_q <= 1'b1;
  end

  assign rdata = rd_virt_q ? v_rdata : p_rdata;

  // R7
  outcome_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(outcome));

  // R7
  syndrome_pairing_chk: assert property (@(posedge clk) disable iff (rst)
    (syndrome != 8'h00) |-> (outcome == 5'b00010 && syndrome == 8'h03));

  // R1
  no_match_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_valid || !hit) |-> (outcome == 5'b00000));

  // R3
  level0_undef_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && hit && priv_lvl == 2'd0) |-> (outcome == 5'b00001));

  // R6
  level3_phys_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && hit && idx_ok && priv_lvl == 2'd3 && ifen_l3) |-> (outcome == 5'b10000));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(p_re || v_re) |=> $stable(rdata));
endmodule

// File: tb/apr_access_gate_test.sv
module apr_access_gate_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [3:0]  enc_coproc = 4'b1111;
  logic [2:0]  enc_opc1 = 3'b000;
  logic [3:0]  enc_crn = 4'b1100;
  logic [3:0]  enc_crm = 4'b1000;
  logic [2:0]  enc_opc2 = 3'b100;
  logic [31:0] wdata = '0;
  logic [1:0]  priv_lvl = 2'd0;
  logic [12:0] ctl = '0;
  logic [4:0]  outcome, outcome_n;
  logic [7:0]  syndrome, syndrome_n;
  logic [31:0] rdata, rdata_n;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // ctl bits: 12 l2_en, 11 l3_present, 10 l3_32b, 9 mon, 8 sd_prio, 7 sd_late,
  // 6 fiq_route, 5 trap_c12, 4 en_l1, 3 en_l2, 2 en_l3, 1 trap_grp0, 0 fiq_virt
  apr_access_gate #(.PRIO_BITS(7)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .enc_coproc(enc_coproc), .enc_opc1(enc_opc1), .enc_crn(enc_crn),
    .enc_crm(enc_crm), .enc_opc2(enc_opc2), .wdata(wdata), .priv_lvl(priv_lvl),
    .l2_enabled(ctl[12]), .l3_present(ctl[11]), .l3_is_32b(ctl[10]),
    .in_monitor(ctl[9]), .sd_undef_prio(ctl[8]), .sd_undef(ctl[7]),
    .l3_fiq_route(ctl[6]), .l2_trap_c12(ctl[5]), .ifen_l1(ctl[4]),
    .ifen_l2(ctl[3]), .ifen_l3(ctl[2]), .l2_trap_grp0(ctl[1]),
    .l2_fiq_virt(ctl[0]), .outcome(outcome), .syndrome(syndrome), .rdata(rdata)
  );

  apr_access_gate #(.PRIO_BITS(5)) uut_narrow (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .enc_coproc(enc_coproc), .enc_opc1(enc_opc1), .enc_crn(enc_crn),
    .enc_crm(enc_crm), .enc_opc2(enc_opc2), .wdata(wdata), .priv_lvl(priv_lvl),
    .l2_enabled(ctl[12]), .l3_present(ctl[11]), .l3_is_32b(ctl[10]),
    .in_monitor(ctl[9]), .sd_undef_prio(ctl[8]), .sd_undef(ctl[7]),
    .l3_fiq_route(ctl[6]), .l2_trap_c12(ctl[5]), .ifen_l1(ctl[4]),
    .ifen_l2(ctl[3]), .ifen_l3(ctl[2]), .l2_trap_grp0(ctl[1]),
    .l2_fiq_virt(ctl[0]), .outcome(outcome_n), .syndrome(syndrome_n), .rdata(rdata_n)
  );

  typedef struct packed {
    logic [1:0]  lvl;
    logic [12:0] c;
    logic [4:0]  exp;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 13'h0010, 5'h10},  // R4 plain physical
    '{2'd1, 13'h0950, 5'h01},  // R4 (a) priority undefine
    '{2'd1, 13'h0F50, 5'h10},  // R4 monitor exemption
    '{2'd1, 13'h1020, 5'h02},  // R4 (b) c12 trap before enable
    '{2'd1, 13'h0020, 5'h01},  // R4 c12 trap needs level 2
    '{2'd1, 13'h1013, 5'h02},  // R4 (d) group-0 trap before virt
    '{2'd1, 13'h1011, 5'h08},  // R4 (e) virtual
    '{2'd1, 13'h0850, 5'h04},  // R4 (f) trap to level 3
    '{2'd1, 13'h08D0, 5'h01},  // R4 (f) late undefine
    '{2'd1, 13'h0011, 5'h10},  // R4 virt needs level 2
    '{2'd2, 13'h0008, 5'h10},  // R5 physical
    '{2'd2, 13'h0000, 5'h01},  // R5 enable off
    '{2'd2, 13'h0E48, 5'h04},  // R5 no monitor exemption
    '{2'd2, 13'h102B, 5'h10},  // R5 level-2 bits ignored
    '{2'd3, 13'h0004, 5'h10},  // R6 physical
    '{2'd3, 13'h0000, 5'h01},  // R6 enable off
    '{2'd0, 13'h1FFF, 5'h01}   // R3 level 0
  };

  function automatic logic [4:0] model(input logic [1:0] lv, input logic [12:0] k);
    logic l2e, l3p, rt;
    l2e = k[12];
    l3p = k[11];
    if (lv == 2'd0) return 5'h01;
    if (lv == 2'd3) return k[2] ? 5'h10 : 5'h01;
    if (lv == 2'd2) begin
      rt = l3p & k[6];
      if (rt & k[8]) return 5'h01;
      if (!k[3])     return 5'h01;
      if (rt)        return k[7] ? 5'h01 : 5'h04;
      return 5'h10;
    end
    rt = l3p & k[6] & (~k[10] | ~k[9]);
    if (rt & k[8])   return 5'h01;
    if (l2e & k[5])  return 5'h02;
    if (!k[4])       return 5'h01;
    if (l2e & k[1])  return 5'h02;
    if (l2e & k[0])  return 5'h08;
    if (rt)          return k[7] ? 5'h01 : 5'h04;
    return 5'h10;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_req(input logic [1:0] lv, input logic [12:0] k, input logic wr,
                         input logic [1:0] ix, input logic [31:0] d);
    priv_lvl  = lv;
    ctl       = k;
    req_write = wr;
    enc_opc2  = {1'b1, ix};
    wdata     = d;
    req_valid = 1'b1;
  endtask

  task automatic idle();
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  // one-cycle access; returns after the edge that commits it
  task automatic access(input logic [1:0] lv, input logic [12:0] k, input logic wr,
                        input logic [1:0] ix, input logic [31:0] d);
    @(negedge clk);
    set_req(lv, k, wr, ix, d);
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 rdata after reset", rdata, 32'h0);
    check("R1 idle outcome", {27'h0, outcome}, 32'h0);
    for (int i = 0; i < 4; i++) begin
      access(2'd3, 13'h0004, 1'b0, i[1:0], 32'h0);
      check("R10 register cleared", rdata, 32'h0);
    end

    // R1 wrong encoding writes nothing
    @(negedge clk);
    set_req(2'd3, 13'h0004, 1'b1, 2'd0, 32'hDEAD_BEEF);
    enc_crm = 4'b1001;
    #1 check("R1 crm mismatch outcome", {27'h0, outcome}, 32'h0);
    enc_crm = 4'b1000;
    enc_opc2 = 3'b000;
    #1 check("R1 opc2 top bit clear", {27'h0, outcome}, 32'h0);
    @(negedge clk);
    idle();
    enc_opc2 = 3'b100;
    access(2'd3, 13'h0004, 1'b0, 2'd0, 32'h0);
    check("R1 mismatched write ignored", rdata, 32'h0);

    // table of chain vectors
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      set_req(VECS[v].lvl, VECS[v].c, 1'b0, 2'd0, 32'h0);
      #1 check("R4/R5 table vector", {27'h0, outcome}, {27'h0, VECS[v].exp});
    end
    @(negedge clk);
    idle();

    // exhaustive sweep of level and controls
    for (int lv = 0; lv < 4; lv++) begin
      for (int k = 0; k < 8192; k++) begin
        @(negedge clk);
        set_req(lv[1:0], k[12:0], 1'b0, 2'd0, 32'h0);
        #1;
        check("R3/R4/R5/R6 sweep outcome", {27'h0, outcome}, {27'h0, model(lv[1:0], k[12:0])});
        check("R7 sweep syndrome", {24'h0, syndrome},
              (model(lv[1:0], k[12:0]) == 5'h02) ? 32'h3 : 32'h0);
      end
    end
    @(negedge clk);
    idle();

    // R8 R9 physical write then read
    access(2'd3, 13'h0004, 1'b1, 2'd2, 32'hA5A5_0002);
    access(2'd3, 13'h0004, 1'b0, 2'd2, 32'h0);
    check("R8 physical write read back", rdata, 32'hA5A5_0002);

    // R8 virtual write lands only in the virtual bank
    access(2'd1, 13'h1011, 1'b1, 2'd1, 32'h1234_5678);
    access(2'd1, 13'h1011, 1'b0, 2'd1, 32'h0);
    check("R9 virtual read", rdata, 32'h1234_5678);
    access(2'd3, 13'h0004, 1'b0, 2'd1, 32'h0);
    check("R8 physical untouched by virtual write", rdata, 32'h0);

    // R8 undefined and trapped writes change nothing
    access(2'd3, 13'h0000, 1'b1, 2'd2, 32'h0000_FFFF);
    @(negedge clk);
    set_req(2'd1, 13'h1020, 1'b1, 2'd2, 32'h0);
    #1 check("R7 trap outcome", {27'h0, outcome}, 32'h02);
    check("R7 trap syndrome", {24'h0, syndrome}, 32'h03);
    @(negedge clk);
    idle();
    access(2'd3, 13'h0004, 1'b0, 2'd2, 32'h0);
    check("R8 blocked writes ignored", rdata, 32'hA5A5_0002);

    // R9 rdata holds across a non-permitted read
    access(2'd0, 13'h1FFF, 1'b0, 2'd1, 32'h0);
    check("R9 rdata held", rdata, 32'hA5A5_0002);

    // R2 narrow build rejects upper indices even at level 3
    @(negedge clk);
    set_req(2'd3, 13'h0004, 1'b0, 2'd1, 32'h0);
    #1 check("R2 narrow index 1 undefined", {27'h0, outcome_n}, 32'h01);
    check("R2 wide index 1 physical", {27'h0, outcome}, 32'h10);
    enc_opc2 = 3'b111;
    #1 check("R2 narrow index 3 undefined", {27'h0, outcome_n}, 32'h01);
    enc_opc2 = 3'b100;
    #1 check("R2 narrow index 0 physical", {27'h0, outcome_n}, 32'h10);
    @(negedge clk);
    idle();

    // R10 reset clears stored values
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 rdata cleared by reset", rdata, 32'h0);
    access(2'd3, 13'h0004, 1'b0, 2'd2, 32'h0);
    check("R10 register cleared by reset", rdata, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule